// File: doc/BRIEF.md
# Chip Erase Sequencer

This block runs the closed-loop erase of a whole nonvolatile byte array through an abstract device port. After a start request it raises the high-voltage flags, applies one chip-wide erase strobe, and then reads the array back one byte at a time. Each byte must read as all ones. If any byte reads otherwise, the whole chip gets another pulse. Once the pulse budget is spent the sequencer gives up and reports failure. A clean verify pass reports success.

The pulse ends on an external pulse-done tick. Ticks that arrive before a minimum width, counted in clock cycles, are ignored. The setup and hold windows for the high-voltage flag and the address-to-read setup are also counted in clock cycles. All of these are parameters, so simulation can shorten them.

Verify does not go back to address zero after a re-erase. It starts at the byte that failed last, runs to the top of the array, wraps to zero and stops just below that starting byte. Every byte is therefore seen in the final pass, and the bytes already known to be good are not read first. The array model and the analog supplies are not part of the block.

Top module: `erase_seq`

## Requirements
- R1: While reset is held and in the first idle cycles after it, busy_o, pass_o, fail_o, ce_o, oe_o, hv_sel_o and vpp_en_o are all 0.
- R2: start_i taken while idle sets busy_o and vpp_en_o, clears the pulse count and resume point, and holds hv_sel_o high for at least SETUP_CYC cycles before ce_o rises.
- R3: ce_o stays high until the first cycle in which pulse_done_i is 1 and at least PULSE_CYC cycles of ce_o have elapsed. In that case the width equals the tick's cycle number. A tick arriving earlier has no effect.
- R4: hv_sel_o stays high for at least HOLD_CYC cycles after ce_o falls. ce_o and oe_o are never high together, and oe_o is high only while hv_sel_o is low and vpp_en_o is high.
- R5: The first verify pass starts at address 0 and moves upward. A byte passes only when rd_data_i is all ones (0xFF for 8 bits) in the single oe_o cycle. addr_o is stable for at least ADDR_SETUP_CYC cycles before oe_o rises.
- R6: The first failing byte in a pass ends the pass with no further reads, and a new chip-wide pulse follows.
- R7: After a re-erase, verify starts at the stored failing address, runs to the top address, wraps to 0 and ends at the address just below the start.
- R8: When every byte of a pass has passed, pass_o is high for exactly one cycle with busy_o low, and vpp_en_o is low.
- R9: If a byte still fails after MAX_PULSES pulses, fail_o is high for one cycle, busy_o drops and no further pulse is applied.
- R10: start_i is ignored while busy_o is high. It is accepted in the cycle in which pass_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an erase run |
| rd_data_i | input | DATA_W | Byte read from the array during oe_o |
| pulse_done_i | input | 1 | Tick from the pulse timer ending the erase pulse |
| addr_o | output | ADDR_W | Array address under verify |
| hv_sel_o | output | 1 | High-voltage erase-select flag |
| vpp_en_o | output | 1 | Program supply enable, high for the whole run |
| ce_o | output | 1 | Erase strobe (chip enable during the pulse) |
| oe_o | output | 1 | Read strobe during verify |
| busy_o | output | 1 | A run is in progress |
| pass_o | output | 1 | One-cycle success flag |
| fail_o | output | 1 | One-cycle give-up flag |

## Verification
Two coincidences are provoked directly.

The first is a pulse-done tick landing in exactly the cycle where the minimum pulse width completes. The bench places the tick on the boundary cycle and expects a pulse of exactly PULSE_CYC cycles. It then places one tick early and another three cycles late, and expects the early tick to be ignored and the pulse to be PULSE_CYC+3 cycles long.

The second is a new start request arriving in the same cycle as the one-cycle pass flag. The bench drives start_i in the cycle where it sees pass_o and expects busy_o high in the next cycle. It also expects a fresh pulse count, with a run of exactly one pulse.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HV_SETUP,
      ST_PULSE,
      ST_HV_HOLD,
      ST_ADDR_SETUP,
      ST_READ
   } seq_state_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/erase_wait_timer.sv
module erase_wait_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] load_val_i,
   output logic          zero_o
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - TW'(1);
   end

   assign zero_o = (cnt_q == '0);

   a_r3_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && (load_val_i != '0) |=> !zero_o);

endmodule

// File: rtl/erase_addr_walker.sv
module erase_addr_walker #(
   parameter int AW     = 4,
   parameter bit RESUME = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          advance_i,
   input  logic          mark_fail_i,
   output logic [AW-1:0] addr_o,
   output logic          last_o
);

   logic [AW-1:0] addr_q;
   logic [AW-1:0] origin;

   generate
      if (RESUME) begin : g_resume
         logic [AW-1:0] resume_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               resume_q <= '0;
            else if (clear_i)
               resume_q <= '0;
            else if (mark_fail_i)
               resume_q <= addr_q;
         end
         assign origin = resume_q;
      end else begin : g_restart
         assign origin = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (clear_i)
         addr_q <= '0;
      else if (mark_fail_i)
         addr_q <= RESUME ? addr_q : '0;
      else if (advance_i)
         addr_q <= addr_q + AW'(1);
   end

   assign addr_o = addr_q;
   assign last_o = ((addr_q + AW'(1)) == origin);

   a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i && !advance_i && !mark_fail_i |=> $stable(addr_o));

   a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (addr_o == '0));

endmodule

// File: rtl/erase_pulse_budget.sv
module erase_pulse_budget #(
   parameter int MAX_PULSES = 10,
   localparam int CW        = $clog2(MAX_PULSES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          bump_i,
   output logic [CW-1:0] count_o,
   output logic          spent_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear_i)
         cnt_q <= '0;
      else if (bump_i && (cnt_q != CW'(MAX_PULSES)))
         cnt_q <= cnt_q + CW'(1);
   end

   assign count_o = cnt_q;
   assign spent_o = (cnt_q == CW'(MAX_PULSES));

   a_r9_budget_cap: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= CW'(MAX_PULSES));

   a_r9_no_bump_when_spent: assert property (@(posedge clk) disable iff (!rst_n)
      spent_o |-> !bump_i);

endmodule

// File: rtl/erase_seq.sv
module erase_seq
   import erase_seq_pkg::*;
#(
   parameter int ADDR_W         = 19,
   parameter int DATA_W         = 8,
   parameter int PULSE_CYC      = 25_000_000,
   parameter int SETUP_CYC      = 100,
   parameter int HOLD_CYC       = 100,
   parameter int ADDR_SETUP_CYC = 100,
   parameter int MAX_PULSES     = 10,
   parameter bit RESUME         = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              pulse_done_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              hv_sel_o,
   output logic              vpp_en_o,
   output logic              ce_o,
   output logic              oe_o,
   output logic              busy_o,
   output logic              pass_o,
   output logic              fail_o
);

   localparam int MAXW = max2(max2(PULSE_CYC, SETUP_CYC), max2(HOLD_CYC, ADDR_SETUP_CYC));
   localparam int TW   = $clog2(MAXW + 1);
   localparam int CW   = $clog2(MAX_PULSES + 1);
   localparam logic [TW-1:0] T_SETUP = TW'(SETUP_CYC - 1);
   localparam logic [TW-1:0] T_PULSE = TW'(PULSE_CYC - 1);
   localparam logic [TW-1:0] T_HOLD  = TW'(HOLD_CYC - 1);
   localparam logic [TW-1:0] T_ASU   = TW'(ADDR_SETUP_CYC - 1);
   localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("erase_seq: widths must be positive");
      end
      if (PULSE_CYC < 1 || SETUP_CYC < 1 || HOLD_CYC < 1 || ADDR_SETUP_CYC < 1) begin : g_bad_time
         $error("erase_seq: every timing window needs at least one cycle");
      end
      if (MAX_PULSES < 1) begin : g_bad_budget
         $error("erase_seq: pulse budget must be at least one");
      end
   endgenerate

   seq_state_t state_q, state_d;
   logic          t_load, t_zero;
   logic [TW-1:0] t_val;
   logic          w_clear, w_adv, w_fail, w_last;
   logic          b_bump, b_spent;
   logic [CW-1:0] b_count;
   logic          pass_d, fail_d, pass_q, fail_q;
   logic          byte_ok;

   assign byte_ok = (rd_data_i == ERASED);

   erase_wait_timer #(.TW(TW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (t_load),
      .load_val_i (t_val),
      .zero_o     (t_zero)
   );

   erase_addr_walker #(.AW(ADDR_W), .RESUME(RESUME)) u_walker (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (w_clear),
      .advance_i   (w_adv),
      .mark_fail_i (w_fail),
      .addr_o      (addr_o),
      .last_o      (w_last)
   );

   erase_pulse_budget #(.MAX_PULSES(MAX_PULSES)) u_budget (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (w_clear),
      .bump_i  (b_bump),
      .count_o (b_count),
      .spent_o (b_spent)
   );

   always_comb begin
      state_d = state_q;
      t_load  = 1'b0;
      t_val   = '0;
      w_clear = 1'b0;
      w_adv   = 1'b0;
      w_fail  = 1'b0;
      b_bump  = 1'b0;
      pass_d  = 1'b0;
      fail_d  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d = ST_HV_SETUP;
               w_clear = 1'b1;
               t_load  = 1'b1;
               t_val   = T_SETUP;
            end
         end
         ST_HV_SETUP: begin
            if (t_zero) begin
               state_d = ST_PULSE;
               b_bump  = 1'b1;
               t_load  = 1'b1;
               t_val   = T_PULSE;
            end
         end
         ST_PULSE: begin
            if (t_zero && pulse_done_i) begin
               state_d = ST_HV_HOLD;
               t_load  = 1'b1;
               t_val   = T_HOLD;
            end
         end
         ST_HV_HOLD: begin
            if (t_zero) begin
               state_d = ST_ADDR_SETUP;
               t_load  = 1'b1;
               t_val   = T_ASU;
            end
         end
         ST_ADDR_SETUP: begin
            if (t_zero)
               state_d = ST_READ;
         end
         ST_READ: begin
            if (byte_ok) begin
               if (w_last) begin
                  state_d = ST_IDLE;
                  pass_d  = 1'b1;
               end else begin
                  state_d = ST_ADDR_SETUP;
                  w_adv   = 1'b1;
                  t_load  = 1'b1;
                  t_val   = T_ASU;
               end
            end else begin
               w_fail = 1'b1;
               if (b_spent) begin
                  state_d = ST_IDLE;
                  fail_d  = 1'b1;
               end else begin
                  state_d = ST_HV_SETUP;
                  t_load  = 1'b1;
                  t_val   = T_SETUP;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pass_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pass_q  <= pass_d;
         fail_q  <= fail_d;
      end
   end

   always_comb begin
      busy_o   = (state_q != ST_IDLE);
      vpp_en_o = busy_o;
      hv_sel_o = (state_q == ST_HV_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HV_HOLD);
      ce_o     = (state_q == ST_PULSE);
      oe_o     = (state_q == ST_READ);
      pass_o   = pass_q;
      fail_o   = fail_q;
   end

   // assertion support: running width of the erase strobe, saturating
   logic [TW:0] ce_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ce_run_q <= '0;
      else if (!ce_o)
         ce_run_q <= '0;
      else if (ce_run_q != '1)
         ce_run_q <= ce_run_q + (TW+1)'(1);
   end

   a_r3_min_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ce_o) |-> (ce_run_q >= (TW+1)'(PULSE_CYC)));

   a_r2_hv_before_ce: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ce_o) |-> $past(hv_sel_o));

   a_r4_hv_after_ce: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ce_o) |-> hv_sel_o);

   a_r4_ce_oe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(ce_o && oe_o));

   a_r4_oe_low_hv: assert property (@(posedge clk) disable iff (!rst_n)
      oe_o |-> (!hv_sel_o && vpp_en_o));

   a_r8_pass_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> ($past(oe_o) && !busy_o && !fail_o));

   a_r9_fail_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> ($past(oe_o) && !busy_o));

   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i |=> (b_count >= $past(b_count)));

   a_r6_fail_repulse: assert property (@(posedge clk) disable iff (!rst_n)
      oe_o && !byte_ok && !b_spent |=> (hv_sel_o && !ce_o));

endmodule

// File: tb/test_erase_seq.sv
module test_erase_seq;

   localparam int AW = 4;
   localparam int DW = 8;
   localparam int N  = 1 << AW;
   localparam int PC = 6;
   localparam int SC = 3;
   localparam int HC = 2;
   localparam int AC = 2;
   localparam int MP = 10;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n, start, pdone;
   logic [DW-1:0] rd;
   logic [AW-1:0] addr;
   logic          hv, vpp, ce, oe, busy, pass, fail;

   erase_seq #(
      .ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PC), .SETUP_CYC(SC),
      .HOLD_CYC(HC), .ADDR_SETUP_CYC(AC), .MAX_PULSES(MP), .RESUME(1'b1)
   ) i_erase_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .rd_data_i(rd),
      .pulse_done_i(pdone), .addr_o(addr), .hv_sel_o(hv), .vpp_en_o(vpp),
      .ce_o(ce), .oe_o(oe), .busy_o(busy), .pass_o(pass), .fail_o(fail)
   );

   int total = 0, bad = 0;
   int need [N];
   int tick_a = PC, tick_b = PC;

   // monitor state
   int  cw = 0, pulses = 0, reads_since = 0, last_width = 0;
   int  first_after [16];
   int  reads_in [16];
   bit  seen [N];
   bit  new_pulse = 0;
   int  pass_cnt = 0, fail_cnt = 0;
   int  v_setup = 0, v_hold = 0, v_asu = 0, v_excl = 0;
   int  hv_run = 0, post = 0, stab = 0;
   logic ce_p = 0, hv_p = 0, oe_p = 0;
   logic [AW-1:0] addr_p = '0;
   int  cycles = 0;

   always_comb begin
      if (oe) rd = (need[addr] == 0) ? 8'hFF : 8'hEF;
      else    rd = 8'h00;
   end

   always_comb pdone = ce && ((cw == tick_a) || (cw == tick_b));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
      if (rst_n) begin
         if (ce && oe) v_excl++;
         if (ce && !ce_p) begin
            if (hv_run < SC) v_setup++;
            pulses++;
            new_pulse = 1;
            reads_since = 0;
            for (int i = 0; i < N; i++) seen[i] = 0;
            cw = 1;
         end else if (ce) cw++;
         if (!ce && ce_p) begin
            last_width = cw;
            post = 0;
            for (int i = 0; i < N; i++) if (need[i] > 0) need[i]--;
         end
         if (hv && !ce && !hv_run_ce_check()) post++;
         if (!hv && hv_p && post < HC) v_hold++;
         if (oe && !oe_p && stab < AC) v_asu++;
         if (oe) begin
            reads_since++;
            if (pulses < 16) reads_in[pulses]++;
            seen[addr] = 1;
            if (new_pulse && pulses < 16) first_after[pulses] = addr;
            new_pulse = 0;
         end
         if (pass) pass_cnt++;
         if (fail) fail_cnt++;
         if (addr != addr_p) stab = 1; else stab++;
         if (hv) hv_run++; else hv_run = 0;
      end
      ce_p = ce; hv_p = hv; oe_p = oe; addr_p = addr;
   end

   // hold window is counted only after the strobe has been high at least once
   function automatic bit hv_run_ce_check();
      return (last_width == 0);
   endfunction

   task automatic clear_stats();
      pulses = 0; reads_since = 0; pass_cnt = 0; fail_cnt = 0; last_width = 0;
      for (int i = 0; i < 16; i++) begin first_after[i] = -1; reads_in[i] = 0; end
   endtask

   task automatic set_need(input int v);
      for (int i = 0; i < N; i++) need[i] = v;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!(pass || fail) && n < 20000) begin
         @(negedge clk);
         n++;
      end
      check(n < 20000, req, n, 20000);
   endtask

   task automatic all_seen(input string req);
      int c = 0;
      for (int i = 0; i < N; i++) c += seen[i];
      check(c == N, req, c, N);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; start = 1'b0;
      set_need(0);
      repeat (3) @(negedge clk);
      check({busy, pass, fail, ce, oe, hv, vpp} == 7'b0, "R1 outputs in reset",
            int'({busy, pass, fail, ce, oe, hv, vpp}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check({busy, pass, fail, ce, oe, hv, vpp} == 7'b0, "R1 outputs after reset",
            int'({busy, pass, fail, ce, oe, hv, vpp}), 0);
   endtask

   task automatic t_clean();
      clear_stats(); set_need(1);
      pulse_start();
      check(busy && vpp && hv && !ce, "R2 flags after start", int'({busy, vpp, hv, ce}), 4'b1110);
      wait_done("R8 clean run ends");
      check(pass == 1'b1 && busy == 1'b0, "R8 pass with busy low", int'({pass, busy}), 2'b10);
      check(vpp == 1'b0, "R8 supply off at pass", int'(vpp), 0);
      check(pulses == 1, "R2 one pulse", pulses, 1);
      check(first_after[1] == 0, "R5 first read at 0", first_after[1], 0);
      check(reads_since == N, "R5 one read per byte", reads_since, N);
      all_seen("R5 every byte read");
      @(negedge clk);
      check(pass == 1'b0, "R8 pass lasts one cycle", int'(pass), 0);
      check(pass_cnt == 1, "R8 single pass flag", pass_cnt, 1);
   endtask

   task automatic t_resume();
      clear_stats(); set_need(1);
      need[3] = 2; need[12] = 3;
      pulse_start();
      wait_done("R7 resume run ends");
      check(pass == 1'b1, "R7 resume run passes", int'(pass), 1);
      check(pulses == 3, "R6 whole-chip re-pulses", pulses, 3);
      check(reads_in[1] == 4, "R6 pass stops at first bad byte", reads_in[1], 4);
      check(first_after[2] == 3, "R7 second pass starts at stored address", first_after[2], 3);
      check(reads_in[2] == 10, "R7 second pass length", reads_in[2], 10);
      check(first_after[3] == 12, "R7 third pass starts at stored address", first_after[3], 12);
      check(reads_in[3] == N, "R7 final pass wraps to cover all", reads_in[3], N);
      all_seen("R7 every byte in final pass");
      @(negedge clk);
   endtask

   task automatic t_fail();
      clear_stats(); set_need(1);
      need[7] = 11;
      pulse_start();
      wait_done("R9 failing run ends");
      check(fail == 1'b1 && pass == 1'b0, "R9 fail flag", int'({fail, pass}), 2'b10);
      check(busy == 1'b0, "R9 busy low at fail", int'(busy), 0);
      check(pulses == MP, "R9 pulse budget", pulses, MP);
      check(reads_in[1] == 8, "R6 first pass reads", reads_in[1], 8);
      check(reads_in[MP] == 1, "R7 last pass resumes at bad byte", reads_in[MP], 1);
      repeat (40) @(negedge clk);
      check(pulses == MP && !ce, "R9 no pulse after giving up", pulses, MP);
      check(fail_cnt == 1, "R9 single fail flag", fail_cnt, 1);
   endtask

   task automatic t_width();
      clear_stats(); set_need(1);
      tick_a = 2; tick_b = PC + 3;
      pulse_start();
      wait_done("R3 late tick run ends");
      check(last_width == PC + 3, "R3 early tick ignored", last_width, PC + 3);
      @(negedge clk);
      clear_stats(); set_need(1);
      tick_a = PC; tick_b = PC;
      pulse_start();
      wait_done("R3 boundary run ends");
      check(last_width == PC, "R3 tick on boundary cycle", last_width, PC);
      @(negedge clk);
   endtask

   task automatic t_start_busy();
      clear_stats(); set_need(1);
      pulse_start();
      repeat (4) @(negedge clk);
      pulse_start();
      repeat (20) @(negedge clk);
      pulse_start();
      wait_done("R10 busy run ends");
      check(pulses == 1, "R10 start while busy ignored", pulses, 1);
      check(reads_since == N, "R10 verify not restarted", reads_since, N);
      @(negedge clk);
   endtask

   task automatic t_start_at_pass();
      clear_stats(); set_need(1);
      pulse_start();
      wait_done("R10 first run ends");
      check(pass == 1'b1, "R10 pass seen", int'(pass), 1);
      clear_stats(); set_need(1);
      pulse_start();
      check(busy == 1'b1, "R10 start in pass cycle accepted", int'(busy), 1);
      wait_done("R10 second run ends");
      check(pass == 1'b1 && pulses == 1, "R10 fresh count after restart", pulses, 1);
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin first_after[i] = -1; reads_in[i] = 0; end
      t_reset();
      t_clean();
      t_resume();
      t_fail();
      t_width();
      t_start_busy();
      t_start_at_pass();
      check(v_setup == 0, "R2 high-voltage setup window", v_setup, 0);
      check(v_hold == 0, "R4 high-voltage hold window", v_hold, 0);
      check(v_excl == 0, "R4 strobes exclusive", v_excl, 0);
      check(v_asu == 0, "R5 address setup window", v_asu, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule